// File: doc/BRIEF.md
# Priority Interrupt Controller with Masking

This block collects a small set of level interrupt requests from peripherals and tells the CPU side which one to take. Each source has a 4-bit priority level and a mask bit. A single register-wide user threshold sets the lowest level that is accepted. Software programs the controller through a simple register bus. The bus has an address, 32-bit write data, byte enables, a write strobe and combinational read data.

Masks have two write paths, so software can change one bit without a read-modify-write. Writing ones through the set window masks sources, and writing ones through the clear window unmasks them. The threshold register is guarded by a key byte, so a stray store cannot lower or raise it. Each cycle the controller picks the highest-level eligible request and presents its level and source index with a valid flag. All three outputs come from flip-flops.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Priority registers sit at address 0x00 + 4*k. Source 4k+j occupies bits [4j+3:4j] of register k. Byte enable 0 writes bits 7:0 and byte enable 1 writes bits 15:8. A read returns the 16-bit value zero-extended, and fields of sources that do not exist read 0.
- R2: Mask-set registers sit at 0x40 + 4*m. The register is a byte, and bit b refers to source 8m+b. A write with byte enable 0 sets each mask bit whose data bit is 1 and leaves the others unchanged. A read returns the current mask byte.
- R3: Mask-clear registers sit at 0x60 + 4*m, with the same bit layout as the set registers. A write with byte enable 0 clears each mask bit whose data bit is 1 and leaves the others unchanged. A read returns 0.
- R4: The user threshold register sits at 0x80. A write changes the level to write data bits 7:4 only when data bits 31:24 equal 0xA5 and byte enables 3 and 0 are both set. Any other write to it is discarded. A read returns the level in bits 7:4 and 0 elsewhere.
- R5: After reset every mask bit is 1, every priority field is 0 and the threshold level is 0. The valid output is 0.
- R6: A source is eligible when its request is 1, its mask bit is 0 and its priority is strictly greater than the threshold level.
- R7: A source with priority 0 is never eligible, even when it is unmasked and requesting.
- R8: Among the eligible sources, the one with the highest priority wins. When levels are equal, the lowest source index wins.
- R9: The valid, level and index outputs update at the clock edge after their inputs change. While no source is eligible, valid is 0 and level and index read 0.
- R10: Writes to unmapped addresses change nothing, and reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_req_i | input | NUM_SRC | Level request per source |
| irq_valid_o | output | 1 | A request is accepted |
| irq_level_o | output | 4 | Level of the winning request |
| irq_src_o | output | SRC_W | Index of the winning request |

## Verification
The arbiter is tried with all 256 request patterns of eight sources, under three configurations:
- distinct priorities, which exposes any error in choosing the highest level;
- tied levels, which separates the lowest-index rule from any other tie order;
- a mix that includes level 0, which shows whether disabled sources are really ignored.

Each configuration is repeated with several threshold levels and mask patterns. This separates a strict comparison from a non-strict one, and shows whether mask bits reach the arbiter. The register side is exercised with patterns that mix ones and zeros in the set and clear windows, with keyed and unkeyed threshold writes, and with partial byte enables.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int unsigned LVL_W       = 4;
   localparam int unsigned PRIO_PER_REG = 4;
   localparam int unsigned MASK_PER_REG = 8;
   localparam logic [2:0]  WIN_PRIO  = 3'b000;
   localparam logic [2:0]  WIN_MSET  = 3'b010;
   localparam logic [2:0]  WIN_MCLR  = 3'b011;
   localparam logic [2:0]  WIN_UMASK = 3'b100;
   localparam logic [7:0]  UMASK_KEY = 8'hA5;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [ADDR_W-1:0]             bus_addr_i,
   input  logic [31:0]                   bus_wdata_i,
   input  logic [3:0]                    bus_be_i,
   input  logic                          bus_we_i,
   output logic [31:0]                   bus_rdata_o,
   output logic [NUM_SRC-1:0][LVL_W-1:0] prio_o,
   output logic [NUM_SRC-1:0]            mask_o,
   output logic [LVL_W-1:0]              ulvl_o
);
   localparam int unsigned NUM_PREG = (NUM_SRC + PRIO_PER_REG - 1) / PRIO_PER_REG;
   localparam int unsigned NUM_MREG = (NUM_SRC + MASK_PER_REG - 1) / MASK_PER_REG;

   logic [NUM_SRC-1:0][LVL_W-1:0] prio_q;
   logic [NUM_SRC-1:0]            mask_q;
   logic [LVL_W-1:0]              ulvl_q;

   // Decoding of the address
   logic       hi_zero, aligned;
   logic [2:0] win;
   logic [2:0] idx;
   logic       hit_prio, hit_mset, hit_mclr, hit_umask;

   if (ADDR_W > 8) begin : g_hi
      assign hi_zero = (bus_addr_i[ADDR_W-1:8] == '0);
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   assign aligned   = (bus_addr_i[1:0] == 2'b00);
   assign win       = bus_addr_i[7:5];
   assign idx       = bus_addr_i[4:2];
   assign hit_prio  = hi_zero && aligned && (win == WIN_PRIO)  && (32'(idx) < NUM_PREG);
   assign hit_mset  = hi_zero && aligned && (win == WIN_MSET)  && (32'(idx) < NUM_MREG);
   assign hit_mclr  = hi_zero && aligned && (win == WIN_MCLR)  && (32'(idx) < NUM_MREG);
   assign hit_umask = hi_zero && aligned && (win == WIN_UMASK) && (idx == 3'd0);

   logic key_ok;
   assign key_ok = (bus_wdata_i[31:24] == UMASK_KEY) && bus_be_i[3] && bus_be_i[0];

   // One storage cell per source
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int unsigned PREG = i / PRIO_PER_REG;
      localparam int unsigned NIB  = i % PRIO_PER_REG;
      localparam int unsigned MREG = i / MASK_PER_REG;
      localparam int unsigned MBIT = i % MASK_PER_REG;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prio_q[i] <= '0;
         end else if (bus_we_i && hit_prio && (32'(idx) == PREG) && bus_be_i[NIB/2]) begin
            prio_q[i] <= bus_wdata_i[LVL_W*NIB +: LVL_W];
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_q[i] <= 1'b1;
         end else if (bus_we_i && bus_be_i[0] && (32'(idx) == MREG) && bus_wdata_i[MBIT]) begin
            if (hit_mset) begin
               mask_q[i] <= 1'b1;
            end else if (hit_mclr) begin
               mask_q[i] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ulvl_q <= '0;
      end else if (bus_we_i && hit_umask && key_ok) begin
         ulvl_q <= bus_wdata_i[7:4];
      end
   end

   // Read path
   logic [NUM_PREG-1:0][15:0] prio_rd;
   logic [NUM_MREG-1:0][7:0]  mask_rd;

   always_comb begin
      prio_rd = '0;
      mask_rd = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         prio_rd[i/PRIO_PER_REG][LVL_W*(i%PRIO_PER_REG) +: LVL_W] = prio_q[i];
         mask_rd[i/MASK_PER_REG][i%MASK_PER_REG]                 = mask_q[i];
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (hit_prio) begin
         bus_rdata_o[15:0] = prio_rd[idx[$clog2(NUM_PREG+1)-1:0]];
      end else if (hit_mset) begin
         bus_rdata_o[7:0] = mask_rd[idx[$clog2(NUM_MREG+1)-1:0]];
      end else if (hit_umask) begin
         bus_rdata_o[7:4] = ulvl_q;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_wdata_i[23:16], bus_wdata_i[3:0], bus_be_i[2]};

   assign prio_o = prio_q;
   assign mask_o = mask_q;
   assign ulvl_o = ulvl_q;

   AST_MSET_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_be_i[0] && hit_mset && idx == 3'd0 && bus_wdata_i[0]) |=> mask_q[0]); // R2
   AST_MCLR_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_be_i[0] && hit_mclr && idx == 3'd0 && bus_wdata_i[0]) |=> !mask_q[0]); // R3
   AST_UMASK_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_wdata_i[31:24] != UMASK_KEY) |=> $stable(ulvl_q)); // R4
   AST_IDLE_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_we_i |=> ($stable(mask_q) && $stable(prio_q) && $stable(ulvl_q))); // R10
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned SRC_W   = 3
) (
   input  logic [NUM_SRC-1:0]            req_i,
   input  logic [NUM_SRC-1:0]            mask_i,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] prio_i,
   input  logic [LVL_W-1:0]              ulvl_i,
   output logic                          valid_o,
   output logic [LVL_W-1:0]              level_o,
   output logic [SRC_W-1:0]              src_o
);
   logic [NUM_SRC-1:0] elig;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign elig[i] = req_i[i] && !mask_i[i] && (prio_i[i] > ulvl_i);
   end

   // Strict comparison, scanning upward: on a tie the lower index is kept
   always_comb begin
      level_o = '0;
      src_o   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (prio_i[i] > level_o)) begin
            level_o = prio_i[i];
            src_o   = SRC_W'(i);
         end
      end
   end

   assign valid_o = |elig;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 8,
   localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   input  logic [3:0]         bus_be_i,
   input  logic               bus_we_i,
   output logic [31:0]        bus_rdata_o,
   input  logic [NUM_SRC-1:0] irq_req_i,
   output logic               irq_valid_o,
   output logic [3:0]         irq_level_o,
   output logic [SRC_W-1:0]   irq_src_o
);
   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic [NUM_SRC-1:0][LVL_W-1:0] prio;
   logic [NUM_SRC-1:0]            mask;
   logic [LVL_W-1:0]              ulvl;
   logic                          win_valid;
   logic [LVL_W-1:0]              win_level;
   logic [SRC_W-1:0]              win_src;

   prio_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_be_i(bus_be_i),
      .bus_we_i(bus_we_i), .bus_rdata_o(bus_rdata_o),
      .prio_o(prio), .mask_o(mask), .ulvl_o(ulvl)
   );

   prio_irq_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) arb_i (
      .req_i(irq_req_i), .mask_i(mask), .prio_i(prio), .ulvl_i(ulvl),
      .valid_o(win_valid), .level_o(win_level), .src_o(win_src)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_valid_o <= 1'b0;
         irq_level_o <= '0;
         irq_src_o   <= '0;
      end else begin
         irq_valid_o <= win_valid;
         irq_level_o <= win_level;
         irq_src_o   <= win_src;
      end
   end

   AST_VALID_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid_o |-> (irq_level_o != '0)); // R7
   AST_ABOVE_THRESHOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ##1 irq_valid_o |-> (irq_level_o > $past(ulvl))); // R6
   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_valid_o |-> (irq_level_o == '0 && irq_src_o == '0)); // R9
   AST_NO_REQ_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_i == '0) |=> !irq_valid_o); // R6
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic [NS-1:0] req = '0;
   logic        vld;
   logic [3:0]  lvl;
   logic [2:0]  src;

   int n_chk = 0;
   int n_fail = 0;

   logic [3:0] m_prio [NS];
   logic [NS-1:0] m_mask;
   logic [3:0] m_ulvl;

   always #5 clk = ~clk;

   prio_irq_ctrl #(.NUM_SRC(NS), .ADDR_W(8)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_be_i(be), .bus_we_i(we),
      .bus_rdata_o(rdata), .irq_req_i(req),
      .irq_valid_o(vld), .irq_level_o(lvl), .irq_src_o(src)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
      @(negedge clk);
      addr = a; wdata = d; be = b; we = 1'b1;
      @(negedge clk);
      we = 1'b0; be = '0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string rq);
      @(negedge clk);
      addr = a; we = 1'b0;
      #1;
      chk(rdata === exp, rq, rdata, exp);
   endtask

   task automatic set_prios(input logic [3:0] p [NS]);
      for (int k = 0; k < NS / 4; k++) begin
         wr(8'(4 * k), {16'h0, p[4*k+3], p[4*k+2], p[4*k+1], p[4*k]}, 4'b0011);
      end
      for (int i = 0; i < NS; i++) m_prio[i] = p[i];
   endtask

   task automatic set_ulvl(input logic [3:0] v);
      wr(8'h80, {8'hA5, 16'h0, v, 4'h0}, 4'b1111);
      m_ulvl = v;
   endtask

   task automatic set_mask(input logic [7:0] m);
      wr(8'h60, 32'hFF, 4'b0001);
      wr(8'h40, {24'h0, m}, 4'b0001);
      m_mask = m;
   endtask

   // Sweep all request patterns; expected winner from R6, R7, R8
   task automatic sweep(input string rq);
      for (int r = 0; r < 256; r++) begin
         logic [3:0] el;
         logic [2:0] es;
         logic ev;
         el = 0; es = 0; ev = 0;
         for (int i = 0; i < NS; i++) begin
            if (r[i] && !m_mask[i] && m_prio[i] > m_ulvl && m_prio[i] > el) begin
               el = m_prio[i]; es = 3'(i); ev = 1'b1;
            end
         end
         @(negedge clk);
         req = 8'(r);
         @(posedge clk);
         #1;
         chk(vld === ev && lvl === el && src === es, rq,
             {vld, lvl, 1'b0, src}, {ev, el, 1'b0, es});
      end
      @(negedge clk);
      req = '0;
   endtask

   initial begin
      #2_000_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [3:0] pa [NS];
      logic [3:0] pb [NS];
      logic [3:0] pc [NS];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 reset state
      #1;
      chk(vld === 1'b0, "R5 valid", vld, 0);
      rd_chk(8'h40, 32'hFF, "R5 mask");
      rd_chk(8'h00, 32'h0, "R5 prio");
      rd_chk(8'h80, 32'h0, "R5 ulvl");

      // R2 / R3 mask windows
      wr(8'h60, 32'h0000_00FF, 4'b0001);
      rd_chk(8'h40, 32'h00, "R3 clear all");
      wr(8'h40, 32'h0000_0005, 4'b0001);
      rd_chk(8'h40, 32'h05, "R2 set some");
      wr(8'h40, 32'h0000_0040, 4'b0001);
      rd_chk(8'h40, 32'h45, "R2 zeros ignored");
      wr(8'h60, 32'h0000_0001, 4'b0001);
      rd_chk(8'h40, 32'h44, "R3 clear one");
      rd_chk(8'h60, 32'h0, "R3 read zero");
      wr(8'h40, 32'h0000_00FF, 4'b0000);
      rd_chk(8'h40, 32'h44, "R2 no byte enable");

      // R1 priority layout and byte enables
      wr(8'h00, 32'h0000_4321, 4'b0011);
      rd_chk(8'h00, 32'h4321, "R1 reg0");
      wr(8'h04, 32'hFFFF_8765, 4'b0001);
      rd_chk(8'h04, 32'h0065, "R1 byte0 only");
      wr(8'h04, 32'h0000_8700, 4'b0010);
      rd_chk(8'h04, 32'h8765, "R1 byte1");

      // R4 keyed threshold
      wr(8'h80, 32'h5A00_0070, 4'b1111);
      rd_chk(8'h80, 32'h0, "R4 bad key");
      wr(8'h80, 32'hA500_0070, 4'b0001);
      rd_chk(8'h80, 32'h0, "R4 key byte disabled");
      wr(8'h80, 32'hA500_0070, 4'b1111);
      rd_chk(8'h80, 32'h70, "R4 good key");
      wr(8'h80, 32'hA5FF_FF0F, 4'b1111);
      rd_chk(8'h80, 32'h0, "R4 reserved bits");

      // R10 unmapped
      wr(8'h84, 32'hFFFF_FFFF, 4'b1111);
      wr(8'h44, 32'hFFFF_FFFF, 4'b1111);
      wr(8'h08, 32'hFFFF_FFFF, 4'b1111);
      rd_chk(8'h84, 32'h0, "R10 read unmapped");
      rd_chk(8'h08, 32'h0, "R10 read past prio");
      rd_chk(8'h40, 32'h44, "R10 mask untouched");
      rd_chk(8'h00, 32'h4321, "R10 prio untouched");
      rd_chk(8'h04, 32'h8765, "R10 prio1 untouched");
      rd_chk(8'h80, 32'h0, "R10 ulvl untouched");

      // R9 registered output timing
      pa = '{4'd3, 4'd8, 4'd13, 4'd2, 4'd7, 4'd12, 4'd1, 4'd6};
      set_prios(pa);
      set_mask(8'h00);
      set_ulvl(4'd0);
      @(negedge clk);
      req = 8'h04;
      #1;
      chk(vld === 1'b0, "R9 not yet valid", vld, 0);
      @(posedge clk);
      #1;
      chk(vld === 1'b1 && lvl === 4'd13 && src === 3'd2, "R9 one cycle", {vld, lvl, src}, {1'b1, 4'd13, 3'd2});
      @(negedge clk);
      req = 8'h00;
      @(posedge clk);
      #1;
      chk(vld === 1'b0 && lvl === 4'd0 && src === 3'd0, "R9 idle zero", {vld, lvl, src}, 0);

      // R8 distinct priorities, R6 thresholds and masks
      set_ulvl(4'd0);  sweep("R8 distinct");
      set_ulvl(4'd6);  sweep("R6 threshold 6");
      set_ulvl(4'd13); sweep("R6 threshold top");
      set_mask(8'hA5); set_ulvl(4'd2); sweep("R6 masked");

      // R8 ties go to lowest index
      pb = '{4'd4, 4'd9, 4'd4, 4'd9, 4'd2, 4'd9, 4'd4, 4'd2};
      set_prios(pb);
      set_mask(8'h00); set_ulvl(4'd0); sweep("R8 ties");
      set_ulvl(4'd4); sweep("R6 tie threshold");
      set_mask(8'h0A); sweep("R8 ties masked");

      // R7 level zero disabled
      pc = '{4'd0, 4'd0, 4'd5, 4'd0, 4'd15, 4'd0, 4'd1, 4'd0};
      set_prios(pc);
      set_mask(8'h00); set_ulvl(4'd0); sweep("R7 zero levels");
      @(negedge clk);
      req = 8'h2B;
      @(posedge clk);
      #1;
      chk(vld === 1'b0, "R7 only level 0 requesting", vld, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule